// File: doc/BRIEF.md
# Reshapeable Two-Port Memory Pair

This block is a 1,152-bit memory with a write port and a read port that run on separate clocks and carry separate address and data buses (9 address bits and 18 data bits on each port inside one bank). A 2-bit shape input turns the same storage into one of four organisations. Narrow shapes use only the low lines of each bus and ignore the rest. The read port has two modes. In registered mode the read enable acts as a clock enable on the read clock. In flow-through mode the data follows the read address through logic alone, and the read enable gates it.

Two identical banks sit side by side to double the depth. The address bit just above the active address field picks the bank. On the write side that bit is decoded onto the two bank write enables. On the read side it steers a multiplexer on the bank outputs. In registered mode that multiplexer uses the select value taken at the read edge. A word keeps its place in the raw bit array whatever the current shape is, so data written in one shape can be read back in another.

Top module: `shapeRamPair`

## Requirements
- R1: The shape code sets the organisation: 0 gives 64x18, 1 gives 128x9, 2 gives 256x4 and 3 gives 512x2. A word at address A of width W occupies raw bits A*W to A*W+W-1 of its bank's 1,152-bit array. Changing the shape leaves the contents untouched.
- R2: On a rising write clock edge with `we` high, the addressed word takes the low W bits of `wData`. Data bits at W and above are ignored.
- R3: Address bits above the active field (6, 7, 8 or 9 bits for shapes 0 to 3) are ignored, apart from the bank select bit.
- R4: With `asyncRd` low, a rising read clock edge with `re` high loads the addressed word into the output register, and it appears on `rData` after that edge.
- R5: With `asyncRd` low and `re` low at a read edge, `rData` keeps its value, even if the address or the stored word changes.
- R6: A registered read and a write to the same word on the same edge return the data stored before that edge.
- R7: With `asyncRd` high and `re` high, `rData` shows the addressed word with no clock edge, including a word written on the previous write edge.
- R8: With `asyncRd` high and `re` low, `rData` is zero.
- R9: Bits of `rData` at W and above are zero.
- R10: Address bit W_A (W_A being the active field width: bit 6, 7, 8 or 9) selects bank 1 when it is high and bank 0 when it is low. A write lands only in the selected bank. A read returns the selected bank's word.
- R11: While `rstN` is low, the registered read output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| rstN | input | 1 | Active-low clear of the read registers |
| mode | input | 2 | Shape code (0:64x18, 1:128x9, 2:256x4, 3:512x2) |
| we | input | 1 | Write enable |
| wAddr | input | 10 | Write address, bank select included |
| wData | input | 18 | Write data |
| re | input | 1 | Read enable |
| rAddr | input | 10 | Read address, bank select included |
| asyncRd | input | 1 | 1 selects flow-through read, 0 selects registered read |
| rData | output | 18 | Read data |

## Verification
A write becomes visible one edge later. A registered read shows up after the read edge that samples `re`, so the bench drives each stimulus on the falling edge and checks the result on the falling edge that follows the next rising edge. A flow-through read needs no edge, so it is checked 1 ns after its inputs change, in the same half cycle. Both ports share one clock in the bench, which puts same-edge read/write collisions and hold-while-writing cases at exact, known cycles. A bench bit-level model of both banks predicts every read value.

// File: rtl/ramPkg.sv
`timescale 1ns/1ps
package ramPkg;
  localparam int ARRAY_BITS = 1152;
  localparam int PORT_AW    = 9;
  localparam int PORT_DW    = 18;
  localparam int BASE_W     = $clog2(ARRAY_BITS);
  localparam int WIDTH_W    = $clog2(PORT_DW + 1);
  localparam int NUM_BANKS  = 2;
  localparam int BANK_AW    = PORT_AW + $clog2(NUM_BANKS);

  typedef struct packed {
    logic              wrStrobe;
    logic              rdStrobe;
    logic [BASE_W-1:0] wrBase;
    logic [BASE_W-1:0] rdBase;
    logic [WIDTH_W-1:0] width;
  } ramStrobeT;

  function automatic logic [WIDTH_W-1:0] widthOf(input logic [1:0] shape);
    case (shape)
      2'd0:    return WIDTH_W'(18);
      2'd1:    return WIDTH_W'(9);
      2'd2:    return WIDTH_W'(4);
      default: return WIDTH_W'(2);
    endcase
  endfunction

  function automatic logic [3:0] addrBitsOf(input logic [1:0] shape);
    return 4'd6 + {2'b00, shape};
  endfunction
endpackage

// File: rtl/ramCtrl.sv
`timescale 1ns/1ps
module ramCtrl
  import ramPkg::*;
(
  input  logic [1:0]         mode,
  input  logic               we,
  input  logic               re,
  input  logic [PORT_AW-1:0] wAddr,
  input  logic [PORT_AW-1:0] rAddr,
  output ramStrobeT          strobes
);
  logic [WIDTH_W-1:0] width;
  logic [PORT_AW-1:0] addrMask;

  always_comb begin
    width    = widthOf(mode);
    addrMask = PORT_AW'((10'd1 << addrBitsOf(mode)) - 10'd1);
    strobes.wrStrobe = we;
    strobes.rdStrobe = re;
    strobes.width    = width;
    strobes.wrBase   = BASE_W'(wAddr & addrMask) * BASE_W'(width);
    strobes.rdBase   = BASE_W'(rAddr & addrMask) * BASE_W'(width);
  end

  always_comb begin
    AST_BASE_RANGE: assert ((int'(strobes.wrBase) + int'(width) <= ARRAY_BITS) &&
                            (int'(strobes.rdBase) + int'(width) <= ARRAY_BITS)); // R1
  end
endmodule

// File: rtl/ramArray.sv
`timescale 1ns/1ps
module ramArray
  import ramPkg::*;
(
  input  logic               wClk,
  input  logic               rClk,
  input  logic               rstN,
  input  logic               asyncRd,
  input  ramStrobeT          strobes,
  input  logic [PORT_DW-1:0] wData,
  output logic [PORT_DW-1:0] rData
);
  logic [ARRAY_BITS-1:0] mem;
  logic [PORT_DW-1:0]    rawRead;
  logic [PORT_DW-1:0]    rReg;

  always_ff @(posedge wClk) begin
    if (strobes.wrStrobe) begin
      for (int k = 0; k < PORT_DW; k++) begin
        if (k < int'(strobes.width)) mem[int'(strobes.wrBase) + k] <= wData[k];
      end
    end
  end

  always_comb begin
    rawRead = '0;
    for (int k = 0; k < PORT_DW; k++) begin
      if (k < int'(strobes.width)) rawRead[k] = mem[int'(strobes.rdBase) + k];
    end
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) rReg <= '0;
    else if (strobes.rdStrobe && !asyncRd) rReg <= rawRead;
  end

  assign rData = asyncRd ? (strobes.rdStrobe ? rawRead : '0) : rReg;
endmodule

// File: rtl/shapeRamCore.sv
`timescale 1ns/1ps
module shapeRamCore
  import ramPkg::*;
(
  input  logic               wClk,
  input  logic               rClk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               we,
  input  logic [PORT_AW-1:0] wAddr,
  input  logic [PORT_DW-1:0] wData,
  input  logic               re,
  input  logic [PORT_AW-1:0] rAddr,
  input  logic               asyncRd,
  output logic [PORT_DW-1:0] rData
);
  ramStrobeT strobes;

  ramCtrl i_ramCtrl (
    .mode(mode), .we(we), .re(re), .wAddr(wAddr), .rAddr(rAddr), .strobes(strobes)
  );

  ramArray i_ramArray (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .asyncRd(asyncRd),
    .strobes(strobes), .wData(wData), .rData(rData)
  );
endmodule

// File: rtl/shapeRamPair.sv
`timescale 1ns/1ps
module shapeRamPair
  import ramPkg::*;
(
  input  logic               wClk,
  input  logic               rClk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               we,
  input  logic [BANK_AW-1:0] wAddr,
  input  logic [PORT_DW-1:0] wData,
  input  logic               re,
  input  logic [BANK_AW-1:0] rAddr,
  input  logic               asyncRd,
  output logic [PORT_DW-1:0] rData
);
  logic [3:0]         selPos;
  logic               wSel;
  logic               rSelNow;
  logic               rSelReg;
  logic [NUM_BANKS-1:0] bankWe;
  logic [PORT_DW-1:0] bankData [NUM_BANKS];

  assign selPos  = addrBitsOf(mode);
  assign wSel    = wAddr[selPos];
  assign rSelNow = rAddr[selPos];

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) rSelReg <= 1'b0;
    else if (re && !asyncRd) rSelReg <= rSelNow;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankWe[b] = we && (wSel == b[0]);
    shapeRamCore i_core (
      .wClk(wClk), .rClk(rClk), .rstN(rstN), .mode(mode),
      .we(bankWe[b]), .wAddr(wAddr[PORT_AW-1:0]), .wData(wData),
      .re(re), .rAddr(rAddr[PORT_AW-1:0]), .asyncRd(asyncRd),
      .rData(bankData[b])
    );
  end

  assign rData = asyncRd ? bankData[rSelNow] : bankData[rSelReg];

  always_comb begin
    if (rstN) begin
      AST_ONE_BANK: assert ($countones(bankWe) == (we ? 1 : 0)); // R10
      AST_FLOW_IDLE_ZERO: assert (!(asyncRd && !re) || rData == '0); // R8
      AST_FLOW_UPPER_ZERO: assert (!asyncRd || (rData >> widthOf(mode)) == '0); // R9
    end
  end

  AST_RD_HOLD: assert property (@(posedge rClk) disable iff (!rstN)
    (!re && !asyncRd) |=> (asyncRd || $stable(rData))); // R5
endmodule

// File: tb/test_shapeRamPair.sv
`timescale 1ns/1ps
module test_shapeRamPair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        we = 1'b0;
  logic [9:0]  wAddr = '0;
  logic [17:0] wData = '0;
  logic        re = 1'b0;
  logic [9:0]  rAddr = '0;
  logic        asyncRd = 1'b0;
  logic [17:0] rData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [1151:0] mdl [2];

  always #2.5 clk = ~clk;

  shapeRamPair i_shapeRamPair (
    .wClk(clk), .rClk(clk), .rstN(rstN), .mode(mode), .we(we), .wAddr(wAddr),
    .wData(wData), .re(re), .rAddr(rAddr), .asyncRd(asyncRd), .rData(rData)
  );

  function automatic int wOf(input logic [1:0] m);
    case (m) 2'd0: return 18; 2'd1: return 9; 2'd2: return 4; default: return 2; endcase
  endfunction

  function automatic logic [17:0] expRead(input logic [1:0] m, input logic [9:0] a);
    int aw = 6 + int'(m);
    int sel = int'(a[aw]);
    int base = int'(a & 10'((1 << aw) - 1)) * wOf(m);
    logic [17:0] v = '0;
    for (int k = 0; k < wOf(m); k++) v[k] = mdl[sel][base + k];
    return v;
  endfunction

  task automatic modelWrite(input logic [1:0] m, input logic [9:0] a, input logic [17:0] d);
    int aw = 6 + int'(m);
    int sel = int'(a[aw]);
    int base = int'(a & 10'((1 << aw) - 1)) * wOf(m);
    for (int k = 0; k < wOf(m); k++) mdl[sel][base + k] = d[k];
  endtask

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [9:0] a, input logic [17:0] d);
    @(negedge clk);
    mode = m; we = 1'b1; wAddr = a; wData = d; re = 1'b0;
    @(posedge clk);
    modelWrite(m, a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic doRegRead(input string req, input logic [1:0] m, input logic [9:0] a);
    logic [17:0] exp;
    @(negedge clk);
    mode = m; asyncRd = 1'b0; re = 1'b1; rAddr = a; we = 1'b0;
    exp = expRead(m, a);
    @(posedge clk);
    @(negedge clk);
    re = 1'b0;
    check(req, rData, exp);
  endtask

  task automatic doFlowRead(input string req, input logic [1:0] m, input logic [9:0] a);
    @(negedge clk);
    mode = m; asyncRd = 1'b1; re = 1'b1; rAddr = a; we = 1'b0;
    #1;
    check(req, rData, expRead(m, a));
    re = 1'b0; asyncRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [17:0] oldV;
    void'($urandom(32'h5EED));
    mdl[0] = '0; mdl[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset output", rData, 18'h0);
    rstN = 1'b1;
    // Fill both banks through shape 0 so model and RAM agree
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 64; a++) doWrite(2'd0, 10'(a | (b << 6)), 18'($urandom));

    // R1 shape change keeps content; shape 0 word 0 all ones read as 2-bit words
    doWrite(2'd0, 10'd0, 18'h3FFFF);
    doRegRead("R1 reshape readback", 2'd3, 10'd0);
    doRegRead("R1 reshape readback 9 wide", 2'd1, 10'd1);
    // R2 upper data ignored, R9 upper output zero
    doWrite(2'd3, 10'd5, 18'h3FFFE);
    doRegRead("R2 R9 narrow write", 2'd3, 10'd5);
    doRegRead("R2 neighbour untouched", 2'd3, 10'd6);
    doFlowRead("R9 flow narrow", 2'd2, 10'd7);
    // R3 upper address bits ignored (shape 0: bits 7,8,9 ignored)
    doWrite(2'd0, 10'h383, 18'h12345);
    doRegRead("R3 upper address ignored", 2'd0, 10'd3);
    // R10 bank select
    doWrite(2'd1, 10'd5, 18'h00AA);
    doWrite(2'd1, 10'd5 | 10'd128, 18'h0155);
    doRegRead("R10 bank0", 2'd1, 10'd5);
    doRegRead("R10 bank1", 2'd1, 10'd133);
    doFlowRead("R10 bank1 flow", 2'd1, 10'd133);
    doWrite(2'd3, 10'h200 | 10'd9, 18'h3);
    doRegRead("R10 bank1 shape3", 2'd3, 10'h209);
    doRegRead("R10 bank0 shape3 untouched", 2'd3, 10'd9);
    // R4 registered read
    doWrite(2'd2, 10'd20, 18'hC);
    doRegRead("R4 registered read", 2'd2, 10'd20);
    // R5 hold while address and stored word change
    oldV = expRead(2'd2, 10'd20);
    @(negedge clk);
    re = 1'b0; rAddr = 10'd21; we = 1'b1; wAddr = 10'd20; wData = 18'h3;
    @(posedge clk);
    modelWrite(2'd2, 10'd20, 18'h3);
    @(negedge clk);
    we = 1'b0;
    check("R5 hold", rData, oldV);
    // R6 same-edge read and write
    oldV = expRead(2'd0, 10'd40);
    @(negedge clk);
    mode = 2'd0; asyncRd = 1'b0; we = 1'b1; wAddr = 10'd40; wData = 18'h2AAAA;
    re = 1'b1; rAddr = 10'd40;
    @(posedge clk);
    modelWrite(2'd0, 10'd40, 18'h2AAAA);
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    check("R6 old data", rData, oldV);
    doRegRead("R6 new data after", 2'd0, 10'd40);
    // R7 flow-through sees the previous edge's write
    doWrite(2'd1, 10'd77, 18'h1F0);
    doFlowRead("R7 flow-through", 2'd1, 10'd77);
    // R8 flow with re low
    @(negedge clk);
    asyncRd = 1'b1; re = 1'b0; rAddr = 10'd77;
    #1;
    check("R8 flow idle zero", rData, 18'h0);
    asyncRd = 1'b0;
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m = 2'($urandom);
      logic [9:0] a = 10'($urandom);
      case ($urandom % 3)
        0: doWrite(m, a, 18'($urandom));
        1: doRegRead("R4 R1 random registered", m, a);
        default: doFlowRead("R7 R1 random flow", m, a);
      endcase
    end
    // R11 reset clears output
    doRegRead("R4 before reset", 2'd0, 10'd0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 reset clears", rData, 18'h0);
    @(negedge clk);
    rstN = 1'b1;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule